// File: doc/BRIEF.md
# Auto-Indexed Calibration Register Bank

This block holds ten 14-bit calibration words behind one data port: a gain word, an offset word and eight DAC trim words. The host never gives an address. A control write picks a subset code and a read-select code. The subset code sets where an internal pointer starts and how far it walks. Each data read or write then goes to the word under the pointer, and the pointer moves on when that access completes. When the last word of the subset has been accessed, the pointer goes back to the start of the subset and a one-cycle flag reports the wrap.

Transfers are either full width (16 bits) or byte wide. In byte mode the low byte goes first and the high byte completes the access. A low-byte write is held in a staging byte, so the stored word changes only together with the high byte. An internal calibration engine can load any word directly by index. When it does, it takes the cycle, and a host data access in that same cycle is dropped.

Top module: `cal_bank`

## Requirements
- R1: After reset, the pointer order is index 0 gain, index 1 offset, indices 2..9 DAC trim 1 (most significant) to 8. Gain and offset reset to 0x2000 and the trims reset to 0x0000. The subset and read-select codes reset to 00.
- R2: Subset code 00 walks all ten words. Code 01 walks gain then offset. Code 10 reaches only offset. Code 11 reaches only gain. The pointer never leaves the selected subset.
- R3: A control write (`ctl_we`=1) loads the subset and read-select codes and moves the pointer to the first word of the subset. That word is offset for code 10 and gain for every other code.
- R4: An access that completes on the last word of the subset returns the pointer to the subset's first word. `wrap` is 1 for exactly the one cycle after that access.
- R5: A full-width write (`byte_mode`=0) stores `wdata[13:0]` and discards `wdata[15:14]`. A full-width read returns the word with bits [15:14] equal to 0.
- R6: In byte mode (`byte_mode`=1), `hi_byte`=0 selects the low byte and `hi_byte`=1 the high byte. A byte read returns the selected byte in `rdata[7:0]` with `rdata[15:8]`=0. A low-byte write only stages `wdata[7:0]` and leaves both the stored word and the pointer unchanged. A high-byte write stores {`wdata[5:0]`, staged byte} and advances the pointer.
- R7: Reads return calibration data and advance the pointer only when the read-select code is 10. For any other code, `rdata` is 0 and a read leaves the pointer unchanged.
- R8: A sequence may be abandoned at any point. The next control write restarts it at the first word of the subset.
- R9: `eng_we`=1 writes `eng_data` into word `eng_idx`, and indices above 9 are ignored. In that cycle any host data read or write is dropped: it stores nothing, stages nothing and does not move the pointer.
- R10: A control write and a data access in the same cycle: the control write takes effect and the data access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_subset | input | 2 | Subset code loaded on a control write |
| ctl_rdsel | input | 2 | Read-select code loaded on a control write (10 = calibration) |
| bus_wr | input | 1 | Data write strobe |
| bus_rd | input | 1 | Data read strobe |
| byte_mode | input | 1 | 1 = byte-wide transfer |
| hi_byte | input | 1 | High-byte select in byte mode |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the word under the pointer |
| eng_we | input | 1 | Calibration engine load strobe |
| eng_idx | input | 4 | Calibration engine target index |
| eng_data | input | 14 | Calibration engine load value |
| wrap | output | 1 | One-cycle pulse after the sequence wraps |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, 14-bit words and eight trim words. With these values the full ten-word walk, the two-word and single-word subsets, and the byte split of 8 bits plus 6 bits are all reached within a few hundred cycles. The random phase mixes subset changes, abandoned sequences, lone low-byte writes, engine loads with indices above 9, and control or engine collisions with host accesses.

// File: rtl/cal_bank.sv
module cal_bank #(
  parameter int DW    = 16,
  parameter int VW    = 14,
  parameter int NTRIM = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_subset,
  input  logic [1:0]    ctl_rdsel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          byte_mode,
  input  logic          hi_byte,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          eng_we,
  input  logic [3:0]    eng_idx,
  input  logic [VW-1:0] eng_data,
  output logic          wrap
);
  localparam int NREG = NTRIM + 2;
  localparam int PW   = $clog2(NREG);
  localparam int BW   = DW / 2;
  localparam logic [PW-1:0] GAIN = '0;
  localparam logic [PW-1:0] OFFS = PW'(1);
  localparam logic [VW-1:0] MID  = VW'(1) << (VW - 1);

  logic [VW-1:0] regs [NREG];
  logic [1:0]    subset_q, rdsel_q;
  logic [PW-1:0] ptr;
  logic [BW-1:0] stage;
  logic          wrap_q;

  function automatic logic [PW-1:0] start_of(input logic [1:0] s);
    return (s == 2'b10) ? OFFS : GAIN;
  endfunction

  function automatic logic [PW-1:0] last_of(input logic [1:0] s);
    case (s)
      2'b00:   return PW'(NREG - 1);
      2'b01:   return OFFS;
      2'b10:   return OFFS;
      default: return GAIN;
    endcase
  endfunction

  wire [PW-1:0] start_idx = start_of(subset_q);
  wire [PW-1:0] last_idx  = last_of(subset_q);
  wire host_ok  = !ctl_we && !eng_we;
  wire rd_ok    = bus_rd && (rdsel_q == 2'b10);
  wire complete = host_ok && (bus_wr || rd_ok) && (!byte_mode || hi_byte);
  wire store    = host_ok && bus_wr && (!byte_mode || hi_byte);
  wire stage_we = host_ok && bus_wr && byte_mode && !hi_byte;
  wire [VW-1:0] host_word = byte_mode ? {wdata[VW-BW-1:0], stage} : wdata[VW-1:0];

  wire [DW-1:0] word     = {{(DW-VW){1'b0}}, regs[ptr]};
  wire [DW-1:0] cal_word = (rdsel_q == 2'b10) ? word : '0;
  assign rdata = !byte_mode ? cal_word :
                 hi_byte    ? {{BW{1'b0}}, cal_word[DW-1:BW]} :
                              {{BW{1'b0}}, cal_word[BW-1:0]};
  assign wrap = wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i < 2) ? MID : '0;
    end else if (eng_we) begin
      if (int'(eng_idx) < NREG) regs[eng_idx] <= eng_data;
    end else if (store) begin
      regs[ptr] <= host_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subset_q <= 2'b00;
      rdsel_q  <= 2'b00;
      ptr      <= GAIN;
      stage    <= '0;
      wrap_q   <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (stage_we) stage <= wdata[BW-1:0];
      if (ctl_we) begin
        subset_q <= ctl_subset;
        rdsel_q  <= ctl_rdsel;
        ptr      <= start_of(ctl_subset);
      end else if (complete) begin
        if (ptr == last_idx) begin
          ptr    <= start_idx;
          wrap_q <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

  // R2
  ptr_in_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr >= start_idx && ptr <= last_idx);
  // R3
  ctl_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ptr == start_idx);
  // R4
  wrap_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> ptr == start_idx);
  // R6
  low_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && byte_mode && !hi_byte) |=> $stable(ptr));
  // R9
  engine_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && !ctl_we) |=> ($stable(ptr) && !wrap));
  // R5
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_mode |-> rdata[DW-1:VW] == '0);
endmodule

// File: tb/cal_bank_tb.sv
module cal_bank_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, bus_wr = 0, bus_rd = 0, byte_mode = 0, hi_byte = 0, eng_we = 0;
  logic [1:0] ctl_subset = 0, ctl_rdsel = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [3:0] eng_idx = 0;
  logic [13:0] eng_data = 0;
  logic wrap;

  always #(CLK_P/2) clk = ~clk;

  cal_bank u_dut (.clk, .rst_n, .ctl_we, .ctl_subset, .ctl_rdsel, .bus_wr, .bus_rd,
                  .byte_mode, .hi_byte, .wdata, .rdata, .eng_we, .eng_idx, .eng_data, .wrap);

  int checks = 0, fails = 0;
  logic [13:0] m [10];
  int mptr = 0;
  logic [1:0] msub = 0, mrd = 0;
  logic [7:0] mstage = 0;

  function automatic int first_of(input logic [1:0] s);
    return (s == 2'b10) ? 1 : 0;
  endfunction
  function automatic int final_of(input logic [1:0] s);
    case (s) 2'b00: return 9; 2'b01: return 1; 2'b10: return 1; default: return 0; endcase
  endfunction
  function automatic logic [15:0] exp_rdata(input logic bm, input logic hb);
    logic [15:0] v;
    v = (mrd == 2'b10) ? {2'b00, m[mptr]} : 16'h0;
    if (!bm) return v;
    return hb ? {8'h0, v[15:8]} : {8'h0, v[7:0]};
  endfunction

  task automatic check(input string tg, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tg, act, expv, $time);
    end
  endtask

  task automatic cyc(input string tg, input logic c, input logic [1:0] s, input logic [1:0] rs,
                     input logic w, input logic r, input logic bm, input logic hb,
                     input logic [15:0] wd, input logic ew, input logic [3:0] ei,
                     input logic [13:0] ed);
    logic wexp;
    @(negedge clk);
    ctl_we = c; ctl_subset = s; ctl_rdsel = rs; bus_wr = w; bus_rd = r;
    byte_mode = bm; hi_byte = hb; wdata = wd; eng_we = ew; eng_idx = ei; eng_data = ed;
    #1;
    if (r) check(tg, rdata, exp_rdata(bm, hb));
    wexp = 0;
    if (ew && ei < 10) m[ei] = ed;
    if (c) begin
      msub = s; mrd = rs; mptr = first_of(s);
    end else if (!ew && (w || (r && mrd == 2'b10))) begin
      if (w) begin
        if (bm && !hb) mstage = wd[7:0];
        else if (bm) m[mptr] = {wd[5:0], mstage};
        else m[mptr] = wd[13:0];
      end
      if (!bm || hb) begin
        if (mptr == final_of(msub)) begin wexp = 1; mptr = first_of(msub); end
        else mptr++;
      end
    end
    @(posedge clk); #1;
    check({tg, " wrap"}, {15'h0, wrap}, {15'h0, wexp});
    ctl_we = 0; bus_wr = 0; bus_rd = 0; eng_we = 0;
  endtask

  task automatic ctl(input string tg, input logic [1:0] s, input logic [1:0] rs);
    cyc(tg, 1, s, rs, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input string tg, input logic [15:0] d);
    cyc(tg, 0, 0, 0, 1, 0, 0, 0, d, 0, 0, 0);
  endtask
  task automatic rd(input string tg);
    cyc(tg, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic bwr(input string tg, input logic hb, input logic [7:0] d);
    cyc(tg, 0, 0, 0, 1, 0, 1, hb, {$urandom_range(255), d}, 0, 0, 0);
  endtask
  task automatic brd(input string tg, input logic hb);
    cyc(tg, 0, 0, 0, 0, 1, 1, hb, 0, 0, 0, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd7341));
    for (int i = 0; i < 10; i++) m[i] = (i < 2) ? 14'h2000 : 14'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 reset rdata", rdata, 16'h0);
    check("R1 reset wrap", {15'h0, wrap}, 16'h0);
    rd("R7 read without select");
    ctl("R3", 2'b00, 2'b10);
    for (int i = 0; i < 10; i++) rd("R1 R2 full walk");
    rd("R4 after wrap");
    ctl("R3", 2'b01, 2'b10);
    wr("R5 top bits dropped", 16'hFFFF);
    wr("R5", 16'hC123);
    rd("R5 readback"); rd("R5 readback");
    ctl("R3 offset only", 2'b10, 2'b10);
    rd("R2 offset only"); rd("R2 offset only");
    ctl("R3 gain only", 2'b11, 2'b10);
    bwr("R6 low", 0, 8'hAB);
    cyc("R6 word unchanged", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    bwr("R6 high", 1, 8'h3C);
    brd("R6 low read", 0); brd("R6 high read", 1);
    rd("R6 full read");
    ctl("R7", 2'b00, 2'b01);
    rd("R7 deselected"); rd("R7 deselected");
    ctl("R8", 2'b00, 2'b10);
    rd("R8"); rd("R8"); rd("R8");
    ctl("R8 restart", 2'b00, 2'b10);
    rd("R8 restart read");
    cyc("R9 engine beats write", 0, 0, 0, 1, 0, 0, 0, 16'h1111, 1, 4'd5, 14'h0AAA);
    cyc("R9 engine beats low byte", 0, 0, 0, 1, 0, 1, 0, 16'h0077, 1, 4'd12, 14'h1234);
    cyc("R10 ctl beats write", 1, 2'b00, 2'b10, 1, 0, 0, 0, 16'h2222, 0, 0, 0);
    for (int i = 0; i < 10; i++) rd("R9 R10 sweep");
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(9);
      case (op)
        0: ctl("R3 rnd", 2'($urandom_range(3)),
               ($urandom_range(3) == 0) ? 2'($urandom_range(3)) : 2'b10);
        1, 2: wr("R5 rnd", 16'($urandom));
        3, 4: rd("R2 rnd");
        5: begin bwr("R6 rnd", 0, 8'($urandom)); bwr("R6 rnd", 1, 8'($urandom)); end
        6: begin brd("R6 rnd", 0); brd("R6 rnd", 1); end
        7: cyc("R9 rnd", 0, 0, 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               16'($urandom), 1, 4'($urandom_range(11)), 14'($urandom));
        8: cyc("R10 rnd", 1, 2'($urandom_range(3)), 2'b10, 1, 0, 1'($urandom), 1'($urandom),
               16'($urandom), 0, 0, 0);
        default: cyc("R6 rnd single", 0, 0, 0, 1'($urandom), 1'($urandom), 1, 1'($urandom),
                     16'($urandom), 0, 0, 0);
      endcase
    end
    ctl("R1 final", 2'b00, 2'b10);
    for (int i = 0; i < 10; i++) rd("R1 final sweep");
    summary();
  end
endmodule